// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block drives a serial flash part that programs two bytes per command in auto-address-increment mode. A request names a start address and a byte count. The block then issues a series of complete commands to a separate serializer, one at a time. Each command is described on a flat command port and closed by a completion pulse. Data bytes come from an external buffer, addressed by the offset of the next byte still to be written.

The sequence has a fixed shape. It polls status until the part is ready and then sends write-enable. An odd start address is handled with a single byte-program, followed by a poll. Next come word commands: only the first carries the address, and each one is followed by a poll. Auto-increment mode ends with write-disable and a poll. A leftover final byte gets its own write-enable, byte-program, poll and write-disable.

Every poll has a retry limit. When a poll reaches that limit, the run stops and a timeout flag is set. The count of bytes already written is kept. A request of zero bytes finishes at once without any bus traffic, and so does a request that runs past the end of the device.

States, in one run:

- `S_IDLE` accepts a request.
- `S_POLL` reads status and returns to the state held in a resume register.
- `S_WREN` sends write-enable and goes to `S_HEAD` when the address is odd, or to `S_PICK` when it is even.
- `S_HEAD` sends the odd-start byte.
- `S_PICK` decides what comes next: `S_WORD` or `S_EXIT` before the mode is left, or `S_TWREN` or finish after it.
- `S_WORD` sends a word command.
- `S_EXIT` sends write-disable.
- `S_TWREN`, then `S_TAIL`, then `S_TEXIT` handle the trailing byte.

Every command state goes back through `S_POLL`, except `S_WREN`, `S_TWREN` and `S_TEXIT`.

Top module: `aai_word_prog`

## Requirements
- R1: A start with a length of 0 gives a `done` pulse in the next cycle. It raises no error flag, sets `written` to 0 and issues no command.
- R2: A start with `req_addr + req_len > MEM_BYTES` is rejected. `done` and `range_err` are high in the next cycle and no command is issued. A request that ends exactly at `MEM_BYTES` is accepted.
- R3: A status poll is opcode 0x05 with `bus_read`=1 and one byte. It is repeated while bit 0 of the returned byte is 1. Every accepted run begins with a poll and then write-enable (opcode 0x06).
- R4: For an odd start address, the first write is opcode 0x02 with the address, `bus_nbytes`=1 and buffer byte 0. A poll follows, and the address then advances by one.
- R5: Each word command is opcode 0xAD with `bus_nbytes`=2. `bus_d0` carries the byte at the lower address. Only the first word command of a run has `bus_addr_en`=1, and each word command is followed by a poll.
- R6: Once fewer than two bytes remain, write-disable (opcode 0x04) is sent and followed by a poll.
- R7: A single remaining byte is written with write-enable, then opcode 0x02 at the current address with one byte, then a poll, then write-disable, and then `done`.
- R8: After `POLL_LIMIT` consecutive status reads with bit 0 set, the run stops. `done` pulses with `timeout_err`=1 and no further command is issued.
- R9: `written` counts the bytes whose program command has completed. It keeps that value after a run ends, including a run that timed out.
- R10: `start` is ignored while `busy` is high.
- R11: `bus_go` is a one-cycle pulse, and no new command is issued until `bus_done` closes the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Byte count |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| timeout_err | output | 1 | Last run ended on a poll timeout |
| range_err | output | 1 | Last request was out of range |
| written | output | LW | Bytes programmed in the last run |
| rd_idx | output | LW | Buffer offset of the next byte |
| rd_lo | input | 8 | Buffer byte at `rd_idx` |
| rd_hi | input | 8 | Buffer byte at `rd_idx`+1 |
| bus_go | output | 1 | Command issue pulse |
| bus_op | output | 8 | Command opcode |
| bus_read | output | 1 | Command reads bytes back |
| bus_addr_en | output | 1 | Address bytes follow the opcode |
| bus_addr | output | AW | Command address |
| bus_nbytes | output | 2 | Data byte count (0 to 2) |
| bus_d0 | output | 8 | First data byte |
| bus_d1 | output | 8 | Second data byte |
| bus_done | input | 1 | Command complete pulse |
| bus_rdata | input | 8 | Status byte, valid with `bus_done` |

## Verification
The assertions check several properties on every cycle:

- The issue pulse lasts one cycle.
- An address on a word command appears only while at most one byte has been written.
- A rejected request finishes in the next cycle without traffic.
- A timeout flag rises only together with `done`.
- The byte count never decreases during a run.

Only the bench scenarios can show that the whole command order is right. This covers:

- the odd-start prologue and the trailing-byte epilogue;
- the data bytes taken from the buffer;
- the retry count of the polls;
- the count kept after a timeout in the middle of a stream;
- a second start during a run being ignored.

// File: rtl/aai_pkg.sv
package aai_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_BYTE = 8'h02;
    localparam logic [7:0] OP_WORD = 8'hAD;

    typedef enum logic [3:0] {
        S_IDLE,
        S_POLL,
        S_WREN,
        S_HEAD,
        S_PICK,
        S_WORD,
        S_EXIT,
        S_TWREN,
        S_TAIL,
        S_TEXIT
    } seq_state_t;
endpackage

// File: rtl/aai_cursor.sv
module aai_cursor #(
    parameter int AW = 24,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [LW-1:0] load_len,
    input  logic          step1,
    input  logic          step2,
    output logic [AW-1:0] cur_addr,
    output logic [LW-1:0] remain,
    output logic [LW-1:0] written
);
    logic [1:0] stride;
    assign stride = step2 ? 2'd2 : (step1 ? 2'd1 : 2'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
            written  <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            remain   <= load_len;
            written  <= '0;
        end else if (step1 || step2) begin
            cur_addr <= cur_addr + AW'(stride);
            remain   <= remain - LW'(stride);
            written  <= written + LW'(stride);
        end
    end
endmodule

// File: rtl/aai_poll_ctr.sv
module aai_poll_ctr #(
    parameter int LIMIT = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (bump)  cnt <= cnt + CW'(1);
    end

    assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/aai_word_prog.sv
module aai_word_prog
    import aai_pkg::*;
#(
    parameter int          AW         = 24,
    parameter int          LW         = 16,
    parameter longint      MEM_BYTES  = 64'd16777216,
    parameter int          POLL_LIMIT = 65536
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    output logic          busy,
    output logic          done,
    output logic          timeout_err,
    output logic          range_err,
    output logic [LW-1:0] written,
    output logic [LW-1:0] rd_idx,
    input  logic [7:0]    rd_lo,
    input  logic [7:0]    rd_hi,
    output logic          bus_go,
    output logic [7:0]    bus_op,
    output logic          bus_read,
    output logic          bus_addr_en,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_nbytes,
    output logic [7:0]    bus_d0,
    output logic [7:0]    bus_d1,
    input  logic          bus_done,
    input  logic [7:0]    bus_rdata
);
    localparam int SW = ((AW > LW) ? AW : LW) + 1;
    localparam logic [SW-1:0] MEM_LIM = SW'(MEM_BYTES);

    seq_state_t    state, resume;
    logic          sent, first_word, exited;
    logic          done_q, tmo_q, rng_q;
    logic [AW-1:0] cur_addr;
    logic [LW-1:0] remain;
    logic          load, step1, step2, cmd_fin, poll_last, out_of_range;
    logic [SW-1:0] req_end;
    logic          unused_status;

    assign unused_status = ^bus_rdata[7:1];
    assign req_end       = SW'(req_addr) + SW'(req_len);
    assign out_of_range  = req_end > MEM_LIM;
    assign cmd_fin       = sent && bus_done;
    assign load          = (state == S_IDLE) && start;
    assign step1         = cmd_fin && ((state == S_HEAD) || (state == S_TAIL));
    assign step2         = cmd_fin && (state == S_WORD);

    aai_cursor #(.AW(AW), .LW(LW)) u_cursor (
        .clk(clk), .rst_n(rst_n), .load(load),
        .load_addr(req_addr), .load_len(req_len),
        .step1(step1), .step2(step2),
        .cur_addr(cur_addr), .remain(remain), .written(written)
    );

    aai_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst_n(rst_n),
        .clear(state != S_POLL),
        .bump((state == S_POLL) && cmd_fin),
        .last(poll_last)
    );

    // state register and sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            resume     <= S_IDLE;
            sent       <= 1'b0;
            first_word <= 1'b0;
            exited     <= 1'b0;
            done_q     <= 1'b0;
            tmo_q      <= 1'b0;
            rng_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (bus_go)  sent <= 1'b1;
            if (cmd_fin) sent <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    tmo_q <= 1'b0;
                    rng_q <= 1'b0;
                    if (req_len == '0) begin
                        done_q <= 1'b1;
                    end else if (out_of_range) begin
                        rng_q  <= 1'b1;
                        done_q <= 1'b1;
                    end else begin
                        state      <= S_POLL;
                        resume     <= S_WREN;
                        first_word <= 1'b1;
                        exited     <= 1'b0;
                    end
                end
                S_POLL: if (cmd_fin) begin
                    if (!bus_rdata[0]) begin
                        state <= resume;
                    end else if (poll_last) begin
                        tmo_q  <= 1'b1;
                        done_q <= 1'b1;
                        state  <= S_IDLE;
                    end
                end
                S_WREN: if (cmd_fin) state <= cur_addr[0] ? S_HEAD : S_PICK;
                S_HEAD: if (cmd_fin) begin
                    state  <= S_POLL;
                    resume <= S_PICK;
                end
                S_PICK: begin
                    if (!exited) begin
                        state <= (remain >= LW'(2)) ? S_WORD : S_EXIT;
                    end else if (remain != '0) begin
                        state <= S_TWREN;
                    end else begin
                        done_q <= 1'b1;
                        state  <= S_IDLE;
                    end
                end
                S_WORD: if (cmd_fin) begin
                    first_word <= 1'b0;
                    state      <= S_POLL;
                    resume     <= S_PICK;
                end
                S_EXIT: if (cmd_fin) begin
                    exited <= 1'b1;
                    state  <= S_POLL;
                    resume <= S_PICK;
                end
                S_TWREN: if (cmd_fin) state <= S_TAIL;
                S_TAIL: if (cmd_fin) begin
                    state  <= S_POLL;
                    resume <= S_TEXIT;
                end
                S_TEXIT: if (cmd_fin) begin
                    done_q <= 1'b1;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // command outputs
    always_comb begin
        bus_go      = 1'b0;
        bus_op      = 8'h00;
        bus_read    = 1'b0;
        bus_addr_en = 1'b0;
        bus_nbytes  = 2'd0;
        bus_d0      = 8'h00;
        bus_d1      = 8'h00;
        unique case (state)
            S_POLL: begin
                bus_go     = !sent;
                bus_op     = OP_RDSR;
                bus_read   = 1'b1;
                bus_nbytes = 2'd1;
            end
            S_WREN, S_TWREN: begin
                bus_go = !sent;
                bus_op = OP_WREN;
            end
            S_HEAD, S_TAIL: begin
                bus_go      = !sent;
                bus_op      = OP_BYTE;
                bus_addr_en = 1'b1;
                bus_nbytes  = 2'd1;
                bus_d0      = rd_lo;
            end
            S_WORD: begin
                bus_go      = !sent;
                bus_op      = OP_WORD;
                bus_addr_en = first_word;
                bus_nbytes  = 2'd2;
                bus_d0      = rd_lo;
                bus_d1      = rd_hi;
            end
            S_EXIT, S_TEXIT: begin
                bus_go = !sent;
                bus_op = OP_WRDI;
            end
            default: ;
        endcase
    end

    assign bus_addr    = cur_addr;
    assign rd_idx      = written;
    assign busy        = (state != S_IDLE);
    assign done        = done_q;
    assign timeout_err = tmo_q;
    assign range_err   = rng_q;

    // R11
    single_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_go |=> !bus_go);

    // R2
    range_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && req_len != '0 && out_of_range) |=> (done && range_err && !bus_go && !busy));

    // R8
    timeout_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> done);

    // R9
    count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (written >= $past(written)));

    // R5
    word_addr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_go && bus_op == OP_WORD && bus_addr_en) |-> (written <= LW'(1)));
endmodule

// File: tb/aai_word_prog_bench.sv
module aai_word_prog_bench;
    localparam int AW  = 24;
    localparam int LW  = 16;
    localparam int MEM = 4096;
    localparam int PL  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          busy, done, timeout_err, range_err;
    logic [LW-1:0] written, rd_idx;
    logic [7:0]    rd_lo, rd_hi;
    logic          bus_go, bus_read, bus_addr_en;
    logic [7:0]    bus_op, bus_d0, bus_d1;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_nbytes;
    logic          bus_done = 1'b0;
    logic [7:0]    bus_rdata = 8'h00;

    always #2 clk = ~clk;

    function automatic logic [7:0] dat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    assign rd_lo = dat(int'(rd_idx));
    assign rd_hi = dat(int'(rd_idx) + 1);

    aai_word_prog #(.AW(AW), .LW(LW), .MEM_BYTES(MEM), .POLL_LIMIT(PL)) u_aai_word_prog (
        .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr), .req_len(req_len),
        .busy(busy), .done(done), .timeout_err(timeout_err), .range_err(range_err),
        .written(written), .rd_idx(rd_idx), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .bus_go(bus_go), .bus_op(bus_op), .bus_read(bus_read), .bus_addr_en(bus_addr_en),
        .bus_addr(bus_addr), .bus_nbytes(bus_nbytes), .bus_d0(bus_d0), .bus_d1(bus_d1),
        .bus_done(bus_done), .bus_rdata(bus_rdata)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [51:0] mk(input logic [7:0] op, input logic rd, input logic ae,
                                       input logic [23:0] a, input logic [1:0] nb,
                                       input logic [7:0] d0, input logic [7:0] d1);
        return {op, rd, ae, (ae ? a : 24'h0), nb, d0, d1};
    endfunction

    // reference model state
    logic [51:0] exp_q[$];
    int  busy_n, hang_burst, m_burst, m_stop, exp_cnt;
    int  r_burst, r_reads, pend;
    logic [7:0] r_resp;

    task automatic m_poll();
        if (m_stop != 0) return;
        if (m_burst == hang_burst) begin
            for (int k = 0; k < PL; k++) exp_q.push_back(mk(8'h05, 1, 0, 0, 2'd1, 0, 0));
            m_stop = 1;
        end else begin
            for (int k = 0; k <= busy_n; k++) exp_q.push_back(mk(8'h05, 1, 0, 0, 2'd1, 0, 0));
            m_burst++;
        end
    endtask

    task automatic build(input int addr, input int len);
        int a, i, first;
        exp_q.delete();
        m_burst = 0; m_stop = 0; exp_cnt = 0;
        if (len == 0 || addr + len > MEM) return;
        a = addr; i = 0; first = 1;
        m_poll();
        if (m_stop != 0) return;
        exp_q.push_back(mk(8'h06, 0, 0, 0, 2'd0, 0, 0));
        if (a % 2 == 1) begin
            exp_q.push_back(mk(8'h02, 0, 1, 24'(a), 2'd1, dat(0), 0));
            exp_cnt = 1; a++; i++;
            m_poll();
        end
        while (m_stop == 0 && len - i >= 2) begin
            exp_q.push_back(mk(8'hAD, 0, first[0], 24'(a), 2'd2, dat(i), dat(i + 1)));
            exp_cnt += 2; a += 2; i += 2; first = 0;
            m_poll();
        end
        if (m_stop != 0) return;
        exp_q.push_back(mk(8'h04, 0, 0, 0, 2'd0, 0, 0));
        m_poll();
        if (m_stop != 0 || i == len) return;
        exp_q.push_back(mk(8'h06, 0, 0, 0, 2'd0, 0, 0));
        exp_q.push_back(mk(8'h02, 0, 1, 24'(a), 2'd1, dat(i), 0));
        exp_cnt++;
        m_poll();
        if (m_stop != 0) return;
        exp_q.push_back(mk(8'h04, 0, 0, 0, 2'd0, 0, 0));
    endtask

    // flash responder and per-clock command comparison
    always @(negedge clk) begin
        bus_done = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                bus_done  = 1'b1;
                bus_rdata = r_resp;
            end
        end
        if (rst_n && bus_go) begin
            logic [51:0] act;
            string tag;
            act = mk(bus_op, bus_read, bus_addr_en, bus_addr, bus_nbytes, bus_d0, bus_d1);
            case (bus_op)
                8'h05:   tag = "R3";
                8'h06:   tag = "R3";
                8'h02:   tag = "R4";
                8'hAD:   tag = "R5";
                8'h04:   tag = "R6";
                default: tag = "R11";
            endcase
            chk(pend == 0, "R11", 64'(pend), 64'd0);
            if (exp_q.size() == 0) begin
                chk(1'b0, tag, 64'(act), 64'h0);
            end else begin
                logic [51:0] e;
                e = exp_q.pop_front();
                chk(act == e, tag, 64'(act), 64'(e));
            end
            r_resp = 8'h00;
            if (bus_read) begin
                if (r_burst == hang_burst) r_resp = 8'h03;
                else if (r_reads < busy_n) begin r_resp = 8'h03; r_reads++; end
                else begin r_reads = 0; r_burst++; end
            end
            pend = 2;
        end
    end

    task automatic run(input int addr, input int len, input int bn, input int hang,
                       input bit exp_rng, input bit poke, input string tag);
        bit got;
        busy_n = bn; hang_burst = hang; r_burst = 0; r_reads = 0;
        build(addr, len);
        @(negedge clk);
        req_addr = AW'(addr);
        req_len  = LW'(len);
        start    = 1'b1;
        got      = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (c == 0) start = 1'b0;
            if (poke && c == 10) begin
                chk(busy == 1'b1, "R10", 64'(busy), 64'd1);
                start = 1'b1; req_len = '0; req_addr = '0;
            end
            if (poke && c == 11) start = 1'b0;
            if (done) begin got = 1'b1; break; end
        end
        chk(got, tag, 64'(got), 64'd1);
        chk(timeout_err == (m_stop != 0), "R8", 64'(timeout_err), 64'(m_stop));
        chk(range_err == exp_rng, "R2", 64'(range_err), 64'(exp_rng));
        chk(int'(written) == exp_cnt, "R9", 64'(written), 64'(exp_cnt));
        chk(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'd0);
        chk(busy == 1'b0, tag, 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        chk(int'(written) == exp_cnt, "R9", 64'(written), 64'(exp_cnt));
    endtask

    initial begin
        pend = 0; busy_n = 0; hang_burst = -1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && bus_go == 0, "R1", 64'({busy, done, bus_go}), 64'd0);
        chk(written == '0, "R9", 64'(written), 64'd0);

        run(16'h10, 6, 0, -1, 0, 0, "R5");
        run(16'h21, 5, 1, -1, 0, 0, "R4");
        run(16'h33, 4, 2, -1, 0, 0, "R7");
        run(16'h40, 1, 0, -1, 0, 0, "R7");
        run(16'h41, 1, 0, -1, 0, 0, "R6");
        run(16'h50, 0, 0, -1, 0, 0, "R1");
        run(4090,  10, 0, -1, 1, 0, "R2");
        run(4092,   4, 0, -1, 0, 0, "R2");
        run(16'h60, 8, 0,  3, 0, 0, "R8");
        run(16'h61, 3, 1,  0, 0, 0, "R8");
        run(16'h71, 7, 1, -1, 0, 1, "R10");
        run(16'h80, 9, 3, -1, 0, 0, "R3");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule